// File: doc/BRIEF.md
# Multicarrier Sinusoidal PWM Generator

This block produces the four comparator decisions that drive a five-level cascaded H-bridge stage. An internal digital sine reference is compared against four digital triangular carriers. Each comparator bit is high while the reference lies strictly above its carrier. A single mode input selects one of two carrier arrangements. In the phase-shifted arrangement all carriers span the full range and are spread evenly in phase. In the level-shifted arrangement each carrier sits in its own amplitude band, and neighbouring bands run in opposite phase.

The reference period is fixed at `4 * 2^ADDR_W` clocks. The carrier frequency is an integer multiple of the reference frequency, set by a ratio input. The reference amplitude is scaled by an amplitude index. The mode and the ratio are sampled only on the last sample of a reference period, so the carriers never jump in the middle of a period. `rst_ni` is asynchronous and active low. Its release is expected to be synchronous to `clk_i`.

Top module: `mc_spwm_gen`

## Requirements
- R1: While `rst_ni` is low, `cmp_o` and `ref_neg_o` are 0. After release, the reference phase counter starts at sample 0.
- R2: The reference phase `p` advances by one per clock modulo `P = 4*2^ADDR_W`. Let `Q = 2^ADDR_W`, `i = p mod Q` and `qd = p / Q`. The unscaled reference magnitude is `round((2^(SAMPLE_W-1)-1) * sin(pi*(a+0.5)/(2Q)))`, where `a = i` for even `qd` and `a = Q-1-i` for odd `qd`. The reference is negative when `qd >= 2`.
- R3: The magnitude is scaled to `floor(mag * A / 2^(AMP_W-1))`, where `A` is `amp_i` limited to at most `2^(AMP_W-1)`. Any larger `amp_i` gives the same result as `2^(AMP_W-1)`. `amp_i` is sampled every clock.
- R4: The carrier phase equals `(p * ratio) mod P`, where `ratio` is the latched ratio. A ratio of 0 holds all carriers still.
- R5: In phase-shifted mode (`mode_i` = 0), carrier `k` uses phase `c + k*P/4`. Its triangle `u` equals `ph` in the first half of `ph` and `P-1-ph` in the second half. Its value is `-2^(SAMPLE_W-1) + u * 2^SAMPLE_W/(P/2)`.
- R6: In level-shifted mode (`mode_i` = 1), carrier `k` uses phase `c + (k mod 2)*P/2`, so neighbouring carriers are in opposite phase. Its value is `-2^(SAMPLE_W-1) + k*2^SAMPLE_W/4 + u*2^SAMPLE_W/(4*P/2)`. The active bits of `cmp_o` therefore always form a run that starts at bit 0.
- R7: `cmp_o[k]` is 1 exactly when the signed reference is strictly greater than carrier `k`. A tie gives 0. An output reflects the phase and `amp_i` from two clocks earlier.
- R8: `ref_neg_o` is 1 during the second half of each reference period, two clocks after the corresponding phase.
- R9: `mode_i` and `ratio_i` are taken only on the clock where `p` wraps from `P-1` to 0. After reset the block runs phase-shifted with ratio `DEF_RATIO` until the first wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Carrier arrangement: 0 phase-shifted, 1 level-shifted with alternate opposition |
| ratio_i | input | FR_W | Carrier-to-reference frequency ratio |
| amp_i | input | AMP_W | Amplitude index, full scale at 2^(AMP_W-1) |
| cmp_o | output | LEVELS-1 | Comparator bit per carrier, bit k for carrier k |
| ref_neg_o | output | 1 | Reference in negative half-period |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives a 256-clock reference period and a 64-entry quarter table. This lets a short run cross many period boundaries. Across those boundaries it changes mode and ratio in mid-period, uses the extreme ratios 0 and 63, and switches repeatedly between the two carrier arrangements. `SAMPLE_W` stays at 12 and `AMP_W` stays at 8. With these values the tie points between a zero reference and a carrier at 0 really occur, and amplitude indices above full scale are available to exercise the saturation path.

// File: rtl/mc_spwm_pkg.sv
package mc_spwm_pkg;

  typedef enum logic {
    MODE_PHASE = 1'b0,
    MODE_LEVEL = 1'b1
  } mc_mode_e;

  localparam real HALF_PI = 1.5707963267948966;

  // Elaboration-time sine sample at the centre of a quarter-table slot.
  function automatic int quarter_sine(input int idx, input int depth, input int peak);
    real x;
    real term;
    real acc;
    x    = HALF_PI * (real'(idx) + 0.5) / real'(depth);
    term = x;
    acc  = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return int'(acc * real'(peak));
  endfunction

endpackage

// File: rtl/mc_spwm_phase.sv
module mc_spwm_phase
  import mc_spwm_pkg::*;
#(
  parameter int PH_W      = 10,
  parameter int FR_W      = 6,
  parameter int DEF_RATIO = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  mc_mode_e        mode_i,
  input  logic [FR_W-1:0] ratio_i,
  output logic [PH_W-1:0] phase_o,
  output logic [PH_W-1:0] cphase_o,
  output mc_mode_e        mode_o
);

  localparam logic [PH_W-1:0] LAST_PH = '1;

  logic [PH_W-1:0] phase_q, phase_d;
  logic [PH_W-1:0] cph_q, cph_d;
  logic [FR_W-1:0] ratio_q;
  mc_mode_e        mode_q;
  logic            period_end;

  // Next-state logic
  always_comb begin
    period_end = (phase_q == LAST_PH);
    phase_d    = phase_q + 1'b1;
    if (period_end) begin
      cph_d = '0;
    end else begin
      cph_d = cph_q + PH_W'(ratio_q);
    end
  end

  // Reference and carrier phase registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cph_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cph_q   <= cph_d;
    end
  end

  // Mode and ratio: loaded only on the wrap clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_PHASE;
      ratio_q <= FR_W'(DEF_RATIO);
    end else if (period_end) begin
      mode_q  <= mode_i;
      ratio_q <= ratio_i;
    end
  end

  assign phase_o  = phase_q;
  assign cphase_o = cph_q;
  assign mode_o   = mode_q;

endmodule

// File: rtl/mc_spwm_sine.sv
module mc_spwm_sine
  import mc_spwm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 12,
  parameter int AMP_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W+1:0]          phase_i,
  input  logic [AMP_W-1:0]           amp_i,
  output logic signed [SAMPLE_W-1:0] ref_o,
  output logic                       neg_o
);

  localparam int PH_W    = ADDR_W + 2;
  localparam int QDEPTH  = 2 ** ADDR_W;
  localparam int MAG_W   = SAMPLE_W - 1;
  localparam int PEAK    = 2 ** MAG_W - 1;
  localparam int AMP_ONE = 2 ** (AMP_W - 1);
  localparam int PROD_W  = MAG_W + AMP_W;

  logic [MAG_W-1:0] lut [QDEPTH];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_lut
    localparam int VAL = quarter_sine(i, QDEPTH, PEAK);
    assign lut[i] = MAG_W'(VAL);
  end

  logic [1:0]                 quad;
  logic [ADDR_W-1:0]          addr;
  logic [MAG_W-1:0]           mag;
  logic [AMP_W-1:0]           amp_c;
  logic [PROD_W-1:0]          prod;
  logic [MAG_W-1:0]           scaled;
  logic signed [SAMPLE_W-1:0] pos;
  logic signed [SAMPLE_W-1:0] ref_d;
  logic signed [SAMPLE_W-1:0] ref_q;
  logic                       neg_q;

  always_comb begin
    quad   = phase_i[PH_W-1 -: 2];
    addr   = quad[0] ? ~phase_i[ADDR_W-1:0] : phase_i[ADDR_W-1:0];
    mag    = lut[addr];
    amp_c  = (amp_i > AMP_W'(AMP_ONE)) ? AMP_W'(AMP_ONE) : amp_i;
    prod   = PROD_W'(mag) * PROD_W'(amp_c);
    scaled = MAG_W'(prod >> (AMP_W - 1));
    pos    = $signed({1'b0, scaled});
    ref_d  = quad[1] ? -pos : pos;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      neg_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      neg_q <= phase_i[PH_W-1];
    end
  end

  assign ref_o = ref_q;
  assign neg_o = neg_q;

endmodule

// File: rtl/mc_spwm_carriers.sv
module mc_spwm_carriers
  import mc_spwm_pkg::*;
#(
  parameter int PH_W     = 10,
  parameter int SAMPLE_W = 12,
  parameter int N_CAR    = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [PH_W-1:0]                 cphase_i,
  input  mc_mode_e                        mode_i,
  output logic [N_CAR-1:0][SAMPLE_W-1:0]  car_o
);

  localparam int P     = 2 ** PH_W;
  localparam int U_W   = PH_W - 1;
  localparam int SH_PS = SAMPLE_W - U_W;
  localparam int SH_LS = SH_PS - $clog2(N_CAR);
  localparam int BAND  = (2 ** SAMPLE_W) / N_CAR;

  for (genvar k = 0; k < N_CAR; k++) begin : g_car
    localparam logic [PH_W-1:0]     OFF_PS  = PH_W'(k * (P / N_CAR));
    localparam logic [PH_W-1:0]     OFF_LS  = PH_W'((k % 2) * (P / 2));
    localparam logic [SAMPLE_W-1:0] BASE_LS = SAMPLE_W'(k * BAND);

    logic [PH_W-1:0]     ph;
    logic [U_W-1:0]      tri_u;
    logic [SAMPLE_W-1:0] ub;
    logic [SAMPLE_W-1:0] car_d;
    logic [SAMPLE_W-1:0] car_q;

    // Fold the phase into a triangle, then place it in offset binary
    always_comb begin
      ph    = cphase_i + ((mode_i == MODE_LEVEL) ? OFF_LS : OFF_PS);
      tri_u = ph[PH_W-1] ? ~ph[U_W-1:0] : ph[U_W-1:0];
      if (mode_i == MODE_LEVEL) begin
        ub = BASE_LS + (SAMPLE_W'(tri_u) << SH_LS);
      end else begin
        ub = SAMPLE_W'(tri_u) << SH_PS;
      end
      car_d = {~ub[SAMPLE_W-1], ub[SAMPLE_W-2:0]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        car_q <= '0;
      end else begin
        car_q <= car_d;
      end
    end

    assign car_o[k] = car_q;
  end

endmodule

// File: rtl/mc_spwm_gen.sv
module mc_spwm_gen
  import mc_spwm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SAMPLE_W  = 12,
  parameter int AMP_W     = 8,
  parameter int FR_W      = 6,
  parameter int LEVELS    = 5,
  parameter int DEF_RATIO = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [FR_W-1:0]   ratio_i,
  input  logic [AMP_W-1:0]  amp_i,
  output logic [LEVELS-2:0] cmp_o,
  output logic              ref_neg_o
);

  localparam int PH_W  = ADDR_W + 2;
  localparam int N_CAR = LEVELS - 1;

  logic [PH_W-1:0]                   phase_w;
  logic [PH_W-1:0]                   cphase_w;
  mc_mode_e                          mode_w;
  logic signed [SAMPLE_W-1:0]        ref_w;
  logic                              neg_w;
  logic [N_CAR-1:0][SAMPLE_W-1:0]    car_w;
  logic [N_CAR-1:0]                  cmp_d;
  logic [N_CAR-1:0]                  cmp_q;
  logic                              neg_q;

  mc_spwm_phase #(
    .PH_W      (PH_W),
    .FR_W      (FR_W),
    .DEF_RATIO (DEF_RATIO)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mc_mode_e'(mode_i)),
    .ratio_i  (ratio_i),
    .phase_o  (phase_w),
    .cphase_o (cphase_w),
    .mode_o   (mode_w)
  );

  mc_spwm_sine #(
    .ADDR_W   (ADDR_W),
    .SAMPLE_W (SAMPLE_W),
    .AMP_W    (AMP_W)
  ) u_sine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase_w),
    .amp_i   (amp_i),
    .ref_o   (ref_w),
    .neg_o   (neg_w)
  );

  mc_spwm_carriers #(
    .PH_W     (PH_W),
    .SAMPLE_W (SAMPLE_W),
    .N_CAR    (N_CAR)
  ) u_carriers (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cphase_i (cphase_w),
    .mode_i   (mode_w),
    .car_o    (car_w)
  );

  // Strict comparison per carrier
  for (genvar k = 0; k < N_CAR; k++) begin : g_cmp
    assign cmp_d[k] = (ref_w > $signed(car_w[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      neg_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      neg_q <= neg_w;
    end
  end

  assign cmp_o     = cmp_q;
  assign ref_neg_o = neg_q;

endmodule

// File: rtl/mc_spwm_gen_chk.sv
module mc_spwm_gen_chk
  import mc_spwm_pkg::*;
#(
  parameter int PH_W  = 10,
  parameter int N_CAR = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CAR-1:0] cmp_o,
  input logic             ref_neg_o,
  input logic [PH_W-1:0]  phase_w,
  input mc_mode_e         mode_w
);

  logic [N_CAR-1:0] cmp_inc;
  assign cmp_inc = cmp_o + 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cmp_o == '0 && !ref_neg_o)); // R1

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (phase_w == PH_W'($past(phase_w) + 1'b1))); // R2

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_w != '0) |-> $stable(mode_w)); // R9

  AST_SIGN_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_neg_o == $past(phase_w[PH_W-1], 2)); // R8

  AST_LEVEL_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_w, 2) == MODE_LEVEL) |-> ((cmp_o & cmp_inc) == '0)); // R6

endmodule

bind mc_spwm_gen mc_spwm_gen_chk #(
  .PH_W  (PH_W),
  .N_CAR (N_CAR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmp_o     (cmp_o),
  .ref_neg_o (ref_neg_o),
  .phase_w   (phase_w),
  .mode_w    (mode_w)
);

// File: tb/mc_spwm_gen_tb_top.sv
module mc_spwm_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int SAMPLE_W   = 12;
  localparam int AMP_W      = 8;
  localparam int FR_W       = 6;
  localparam int LEVELS     = 5;
  localparam int DEF_RATIO  = 6;
  localparam int N_CAR      = LEVELS - 1;
  localparam int Q          = 2 ** ADDR_W;
  localparam int P          = 4 * Q;
  localparam int R          = 2 ** (SAMPLE_W - 1);
  localparam int AMP_ONE    = 2 ** (AMP_W - 1);
  localparam real PI        = 3.141592653589793;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              mode_i;
  logic [FR_W-1:0]   ratio_i;
  logic [AMP_W-1:0]  amp_i;
  logic [N_CAR-1:0]  cmp_o;
  logic              ref_neg_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    chk_en   = 1'b0;
  bit    done     = 1'b0;
  string cur_req  = "R1 reset";

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc_spwm_gen #(
    .ADDR_W    (ADDR_W),
    .SAMPLE_W  (SAMPLE_W),
    .AMP_W     (AMP_W),
    .FR_W      (FR_W),
    .LEVELS    (LEVELS),
    .DEF_RATIO (DEF_RATIO)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .ratio_i   (ratio_i),
    .amp_i     (amp_i),
    .cmp_o     (cmp_o),
    .ref_neg_o (ref_neg_o)
  );

  // Reference value per requirement text (R2, R3)
  function automatic int ref_model(input int ph, input int amp);
    int qd, idx, a, mag, ac, s;
    qd  = ph / Q;
    idx = ph % Q;
    a   = (qd % 2 == 1) ? (Q - 1 - idx) : idx;
    mag = int'(real'(R - 1) * $sin(PI * (real'(a) + 0.5) / real'(2 * Q)));
    ac  = (amp > AMP_ONE) ? AMP_ONE : amp;
    s   = (mag * ac) / AMP_ONE;
    return (qd >= 2) ? -s : s;
  endfunction

  // Carrier value per requirement text (R4, R5, R6)
  function automatic int car_model(input int cph, input int lvl, input int k);
    int off, ph, u;
    off = lvl ? (k % 2) * (P / 2) : k * (P / N_CAR);
    ph  = (cph + off) % P;
    u   = (ph < P / 2) ? ph : (P - 1 - ph);
    if (lvl) return -R + k * (2 * R / N_CAR) + u * ((2 * R / N_CAR) / (P / 2));
    else     return -R + u * (2 * R / (P / 2));
  endfunction

  // Cycle model: phase state, stage-1 values, expected outputs
  int              m_phase, m_mode, m_ratio, m_ref, m_neg1;
  int              m_car [N_CAR];
  logic [N_CAR-1:0] exp_cmp;
  logic            exp_neg;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_mode = 0; m_ratio = DEF_RATIO; m_ref = 0; m_neg1 = 0;
      for (int k = 0; k < N_CAR; k++) m_car[k] = 0;
      exp_cmp = '0; exp_neg = 1'b0;
    end else begin
      for (int k = 0; k < N_CAR; k++) exp_cmp[k] = (m_ref > m_car[k]);
      exp_neg = (m_neg1 != 0);
      m_ref  = ref_model(m_phase, int'(amp_i));
      m_neg1 = (m_phase >= P / 2) ? 1 : 0;
      for (int k = 0; k < N_CAR; k++)
        m_car[k] = car_model((m_phase * m_ratio) % P, m_mode, k);
      if (m_phase == P - 1) begin
        m_mode  = int'(mode_i);
        m_ratio = int'(ratio_i);
      end
      m_phase = (m_phase + 1) % P;
    end
  end

  // Continuous comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && chk_en && !done) begin
      n_checks++;
      if (cmp_o !== exp_cmp) begin
        n_errors++;
        $display("FAIL %s (R7 compare) cmp_o actual %b expected %b at %0t",
                 cur_req, cmp_o, exp_cmp, $time);
      end
      n_checks++;
      if (ref_neg_o !== exp_neg) begin
        n_errors++;
        $display("FAIL R8 ref_neg_o actual %b expected %b at %0t",
                 ref_neg_o, exp_neg, $time);
      end
    end
  end

  task automatic check_reset();
    n_checks++;
    if (cmp_o !== '0 || ref_neg_o !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 reset outputs actual %b/%b expected 0000/0",
               cmp_o, ref_neg_o);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    report();
  end

  initial begin
    void'($urandom(32'h1357_2468));
    mode_i  = 1'b1;
    ratio_i = FR_W'(3);
    amp_i   = AMP_W'(AMP_ONE);
    rst_ni  = 1'b1;
    #1 rst_ni = 1'b0;
    cur_req = "R1 reset";
    repeat (4) begin @(negedge clk); check_reset(); end
    rst_ni = 1'b1;
    chk_en = 1'b1;

    // First period must ignore mode_i=1, ratio_i=3 (defaults hold)
    cur_req = "R9 defaults after reset";
    run(P / 2);
    mode_i = 1'b0; ratio_i = FR_W'(9);
    run(P / 2);
    cur_req = "R9 mid-period change";
    run(P / 3);
    mode_i = 1'b1; ratio_i = FR_W'(4);
    run(P + P / 2);

    cur_req = "R5 phase-shifted";
    mode_i = 1'b0; ratio_i = FR_W'(6);
    run(2 * P);
    ratio_i = FR_W'(11);
    run(2 * P);

    cur_req = "R6 level-shifted";
    mode_i = 1'b1; ratio_i = FR_W'(6);
    run(2 * P);
    ratio_i = FR_W'(13);
    run(2 * P);

    cur_req = "R7 ties at zero amplitude";
    amp_i = '0; mode_i = 1'b0; ratio_i = FR_W'(6);
    run(2 * P);
    mode_i = 1'b1;
    run(2 * P);

    cur_req = "R3 amplitude saturation";
    amp_i = AMP_W'(200); mode_i = 1'b0;
    run(2 * P);
    amp_i = AMP_W'(255);
    run(P);
    amp_i = AMP_W'(64);
    run(P);

    cur_req = "R4 ratio extremes";
    amp_i = AMP_W'(AMP_ONE); ratio_i = '0;
    run(2 * P);
    ratio_i = FR_W'(63); mode_i = 1'b1;
    run(2 * P);
    ratio_i = FR_W'(1);
    run(2 * P);

    cur_req = "R2 random stimulus";
    for (int seg = 0; seg < 24; seg++) begin
      mode_i  = 1'($urandom % 2);
      ratio_i = FR_W'($urandom % (2 ** FR_W));
      for (int j = 0; j < P / 16; j++) begin
        amp_i = AMP_W'($urandom % (2 ** AMP_W));
        run(16);
      end
    end

    cur_req = "R1 reset in mid-run";
    chk_en = 1'b0;
    run(P / 5);
    rst_ni = 1'b0;
    repeat (3) begin @(negedge clk); check_reset(); end
    mode_i = 1'b1; ratio_i = FR_W'(5); amp_i = AMP_W'(100);
    rst_ni = 1'b1;
    chk_en = 1'b1;
    cur_req = "R9 defaults after second reset";
    run(2 * P);

    report();
  end

endmodule